// File: doc/BRIEF.md
# Ternary Prefix Match Table

This block is a small content-addressable lookup table for longest prefix routing on 32-bit keys. Every entry keeps a value word, a per-bit care word and a valid flag. A care bit of 1 means that bit position is compared during a lookup. A care bit of 0 means the position is ignored. A lookup compares one key against every valid entry in the same cycle. It returns a hit flag and the index of the matching entry with the smallest address. If software stores entries in order of falling prefix length, that index is the longest matching prefix.

A table-wide filter word acts on both paths. On a store, only the bit positions where the filter is 1 change. On a lookup, only the key positions where the filter is 1 are compared. Software reaches the entries through a burst engine. A command gives an operation, a start address and a length. The data beats that follow each act on one entry, and the address steps up by one per beat, so whole blocks of entries can be moved with one command each.

Top module: `prefixMatchTable`

## Requirements
- R1: After reset every entry is invalid, all stored words are zero, the filter word is all ones, and no burst is active, so a lookup of any key reports no hit.
- R2: A lookup accepted on `srchEn` gives `srchValid` high on the next clock edge with its result. With no match, `srchHit` is 0 and `srchIdx` is 0. `srchValid`, `srchHit` and `srchIdx` are all zero in cycles that follow no lookup.
- R3: An entry matches a key when the entry is valid and the key equals the entry's value word at every bit where both the entry's care word and the filter word are 1.
- R4: When several entries match, `srchIdx` reports the lowest matching address.
- R5: A beat of a value-store (`cmdOp` 2'b00) or care-store (`cmdOp` 2'b01) burst changes only the bits where the filter word is 1. The other bits keep their old contents. A value store also marks the entry valid.
- R6: The filter word is loaded from `gmaskIn` when `gmaskWe` is high and takes effect from the next cycle. Key positions where it is 0 are excluded from every comparison.
- R7: `cmdStart` while idle starts a burst with operation `cmdOp`, address `cmdAddr` and `cmdLen`+1 beats. A beat is taken only in a cycle with `beatEn` high. After each beat the address steps by one and wraps from DEPTH-1 to 0. `burstBusy` stays high until the last beat.
- R8: `burstDone` is high for exactly one cycle, the cycle after the last beat is taken, and `burstBusy` is low in that cycle.
- R9: A beat of a read burst (`cmdOp` 2'b10) gives `rdValid` high on the next edge, together with the entry's value word, care word and valid flag. The read outputs are zero in other cycles.
- R10: A beat of an invalidate burst (`cmdOp` 2'b11) clears the entry's valid flag, and an invalid entry never matches.
- R11: A lookup in the same cycle as a store sees the table as it was before that store. The new contents take effect from the following cycle.
- R12: `cmdStart` during an active burst is ignored, and `beatEn` while idle changes no entry.
- R13: With entries sorted by prefix length (/25 192.168.104.228, /24 192.168.104.100, /23 192.168.105.100, /22 192.168.106.100 at addresses 0 to 3), key 192.168.104.127 matches addresses 1, 2 and 3, misses address 0, and reports address 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| gmaskWe | input | 1 | Load the filter word |
| gmaskIn | input | KEY_W | New filter word |
| cmdStart | input | 1 | Start a burst (taken only when idle) |
| cmdOp | input | 2 | Burst operation: 00 value store, 01 care store, 10 read, 11 invalidate |
| cmdAddr | input | IDX_W | First entry address of the burst |
| cmdLen | input | IDX_W | Number of beats minus one |
| beatEn | input | 1 | Data beat for the active burst |
| beatData | input | KEY_W | Beat payload for store operations |
| burstBusy | output | 1 | A burst is active |
| burstDone | output | 1 | One-cycle pulse after the last beat |
| rdValid | output | 1 | Read result valid |
| rdData | output | KEY_W | Value word read back |
| rdMask | output | KEY_W | Care word read back |
| rdEntValid | output | 1 | Valid flag read back |
| srchEn | input | 1 | Start a lookup |
| srchKey | input | KEY_W | Lookup key |
| srchValid | output | 1 | Lookup result valid |
| srchHit | output | 1 | At least one entry matched |
| srchIdx | output | IDX_W | Lowest matching address |

## Verification
The embedded properties assume that `cmdOp` is held only for the cycle of `cmdStart` and that reset is asserted at time zero. They also assume DEPTH is a power of two, so every address the burst counter can reach names a real entry. The stimulus honours this. It drives every input just after the falling edge, keeps `cmdAddr` and `cmdLen` inside the table, and drives lookups, beats and filter loads in any mix, including a store and a lookup to the same entry in one cycle. The random phase also issues new commands while a burst is active and beats while idle, because the block is specified to ignore them.

// File: rtl/tcam_pkg.sv
package tcam_pkg;

  typedef enum logic [1:0] {
    OP_WDATA = 2'b00,
    OP_WMASK = 2'b01,
    OP_READ  = 2'b10,
    OP_INVAL = 2'b11
  } tblOp_e;

  // per-beat strobes from burst control to the entry array
  typedef struct packed {
    logic wrData;
    logic wrMask;
    logic rdEnt;
    logic inval;
  } beatStb_t;

endpackage

// File: rtl/tcamPrioEnc.sv
module tcamPrioEnc #(
  parameter int DEPTH = 16,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [DEPTH-1:0] matchVec,
  output logic             anyHit,
  output logic [IDX_W-1:0] hitIdx
);

  // lowest set bit wins: scan from the top so lower indices overwrite
  always_comb begin
    anyHit = |matchVec;
    hitIdx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (matchVec[i]) hitIdx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/tcamBurstCtrl.sv
module tcamBurstCtrl
  import tcam_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdStart,
  input  logic [1:0]       cmdOp,
  input  logic [IDX_W-1:0] cmdAddr,
  input  logic [IDX_W-1:0] cmdLen,
  input  logic             beatEn,
  output beatStb_t         stb,
  output logic [IDX_W-1:0] beatAddr,
  output logic             busy,
  output logic             done
);

  localparam logic [IDX_W-1:0] LAST_ADDR = IDX_W'(DEPTH - 1);

  logic             busyQ;
  logic             doneQ;
  logic [IDX_W-1:0] addrQ;
  logic [IDX_W-1:0] remQ;
  tblOp_e           opQ;
  logic             beatGo;
  logic [IDX_W-1:0] addrNext;

  assign beatGo   = busyQ && beatEn;
  assign addrNext = (addrQ == LAST_ADDR) ? '0 : addrQ + 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      doneQ <= 1'b0;
      addrQ <= '0;
      remQ  <= '0;
      opQ   <= OP_WDATA;
    end else begin
      doneQ <= 1'b0;
      if (!busyQ && cmdStart) begin
        busyQ <= 1'b1;
        addrQ <= cmdAddr;
        remQ  <= cmdLen;
        opQ   <= tblOp_e'(cmdOp);
      end else if (beatGo) begin
        addrQ <= addrNext;
        if (remQ == '0) begin
          busyQ <= 1'b0;
          doneQ <= 1'b1;
        end else begin
          remQ <= remQ - 1'b1;
        end
      end
    end
  end

  always_comb begin
    stb        = '0;
    stb.wrData = beatGo && (opQ == OP_WDATA);
    stb.wrMask = beatGo && (opQ == OP_WMASK);
    stb.rdEnt  = beatGo && (opQ == OP_READ);
    stb.inval  = beatGo && (opQ == OP_INVAL);
  end

  assign beatAddr = addrQ;
  assign busy     = busyQ;
  assign done     = doneQ;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |=> !doneQ); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |-> !busyQ); // R8
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && cmdStart && !beatEn) |=> ($stable(addrQ) && $stable(opQ) && busyQ)); // R12
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && beatEn && remQ != '0) |=>
      (busyQ && addrQ == (($past(addrQ) == LAST_ADDR) ? '0 : $past(addrQ) + 1'b1))); // R7
  AST_NO_BEAT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && !beatEn) |=> (busyQ && $stable(remQ))); // R7

endmodule

// File: rtl/tcamEntryArray.sv
module tcamEntryArray
  import tcam_pkg::*;
#(
  parameter int KEY_W = 32,
  parameter int DEPTH = 16,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  beatStb_t         stb,
  input  logic [IDX_W-1:0] beatAddr,
  input  logic [KEY_W-1:0] beatData,
  input  logic             gmaskWe,
  input  logic [KEY_W-1:0] gmaskIn,
  input  logic             srchEn,
  input  logic [KEY_W-1:0] srchKey,
  output logic             srchValid,
  output logic             srchHit,
  output logic [IDX_W-1:0] srchIdx,
  output logic             rdValid,
  output logic [KEY_W-1:0] rdData,
  output logic [KEY_W-1:0] rdMask,
  output logic             rdEntValid
);

  logic [KEY_W-1:0] dataMem [DEPTH];
  logic [KEY_W-1:0] maskMem [DEPTH];
  logic [DEPTH-1:0] validVec;
  logic [KEY_W-1:0] gmaskQ;
  logic [DEPTH-1:0] matchVec;
  logic [DEPTH-1:0] belowHit;
  logic             anyHit;
  logic [IDX_W-1:0] hitIdx;

  // one comparator per entry, all evaluated in the same cycle
  for (genvar g = 0; g < DEPTH; g++) begin : gCmp
    assign matchVec[g] = validVec[g] &&
      (((srchKey ^ dataMem[g]) & maskMem[g] & gmaskQ) == '0);
    assign belowHit[g] = (IDX_W'(g) < hitIdx);
  end

  tcamPrioEnc #(.DEPTH(DEPTH)) uEnc (
    .matchVec (matchVec),
    .anyHit   (anyHit),
    .hitIdx   (hitIdx)
  );

  // storage: filtered merge on stores, valid set by value store
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) begin
        dataMem[i] <= '0;
        maskMem[i] <= '0;
      end
      validVec <= '0;
      gmaskQ   <= '1;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (IDX_W'(i) == beatAddr) begin
          if (stb.wrData) begin
            dataMem[i]  <= (dataMem[i] & ~gmaskQ) | (beatData & gmaskQ);
            validVec[i] <= 1'b1;
          end
          if (stb.wrMask) begin
            maskMem[i] <= (maskMem[i] & ~gmaskQ) | (beatData & gmaskQ);
          end
          if (stb.inval) begin
            validVec[i] <= 1'b0;
          end
        end
      end
      if (gmaskWe) gmaskQ <= gmaskIn;
    end
  end

  // registered lookup and read results
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srchValid  <= 1'b0;
      srchHit    <= 1'b0;
      srchIdx    <= '0;
      rdValid    <= 1'b0;
      rdData     <= '0;
      rdMask     <= '0;
      rdEntValid <= 1'b0;
    end else begin
      srchValid  <= srchEn;
      srchHit    <= srchEn && anyHit;
      srchIdx    <= (srchEn && anyHit) ? hitIdx : '0;
      rdValid    <= stb.rdEnt;
      rdData     <= stb.rdEnt ? dataMem[beatAddr] : '0;
      rdMask     <= stb.rdEnt ? maskMem[beatAddr] : '0;
      rdEntValid <= stb.rdEnt && validVec[beatAddr];
    end
  end

  AST_MISS_IDX_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (srchValid && !srchHit) |-> (srchIdx == '0)); // R2
  AST_HIT_NEEDS_SRCH: assert property (@(posedge clk) disable iff (!rstN)
    srchHit |-> srchValid); // R2
  AST_SRCH_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    srchEn |=> srchValid); // R2
  AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rstN)
    anyHit |-> (matchVec[hitIdx] && ((matchVec & belowHit) == '0))); // R4
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stb)); // R7
  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    stb.rdEnt |=> rdValid); // R9
  AST_INVAL_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    stb.inval |=> !validVec[$past(beatAddr)]); // R10

endmodule

// File: rtl/prefixMatchTable.sv
module prefixMatchTable
  import tcam_pkg::*;
#(
  parameter int KEY_W = 32,
  parameter int DEPTH = 16,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             gmaskWe,
  input  logic [KEY_W-1:0] gmaskIn,
  input  logic             cmdStart,
  input  logic [1:0]       cmdOp,
  input  logic [IDX_W-1:0] cmdAddr,
  input  logic [IDX_W-1:0] cmdLen,
  input  logic             beatEn,
  input  logic [KEY_W-1:0] beatData,
  output logic             burstBusy,
  output logic             burstDone,
  output logic             rdValid,
  output logic [KEY_W-1:0] rdData,
  output logic [KEY_W-1:0] rdMask,
  output logic             rdEntValid,
  input  logic             srchEn,
  input  logic [KEY_W-1:0] srchKey,
  output logic             srchValid,
  output logic             srchHit,
  output logic [IDX_W-1:0] srchIdx
);

  beatStb_t         stb;
  logic [IDX_W-1:0] beatAddr;

  tcamBurstCtrl #(.DEPTH(DEPTH)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdStart (cmdStart),
    .cmdOp    (cmdOp),
    .cmdAddr  (cmdAddr),
    .cmdLen   (cmdLen),
    .beatEn   (beatEn),
    .stb      (stb),
    .beatAddr (beatAddr),
    .busy     (burstBusy),
    .done     (burstDone)
  );

  tcamEntryArray #(.KEY_W(KEY_W), .DEPTH(DEPTH)) uArray (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .beatAddr   (beatAddr),
    .beatData   (beatData),
    .gmaskWe    (gmaskWe),
    .gmaskIn    (gmaskIn),
    .srchEn     (srchEn),
    .srchKey    (srchKey),
    .srchValid  (srchValid),
    .srchHit    (srchHit),
    .srchIdx    (srchIdx),
    .rdValid    (rdValid),
    .rdData     (rdData),
    .rdMask     (rdMask),
    .rdEntValid (rdEntValid)
  );

endmodule

// File: tb/sim_prefixMatchTable.sv
module sim_prefixMatchTable;

  localparam int CLK_PERIOD = 10;
  localparam int KEY_W      = 32;
  localparam int DEPTH      = 16;
  localparam int IDX_W      = 4;
  localparam int WATCHDOG   = 50000;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             gmaskWe = 1'b0;
  logic [KEY_W-1:0] gmaskIn = '0;
  logic             cmdStart = 1'b0;
  logic [1:0]       cmdOp = '0;
  logic [IDX_W-1:0] cmdAddr = '0;
  logic [IDX_W-1:0] cmdLen = '0;
  logic             beatEn = 1'b0;
  logic [KEY_W-1:0] beatData = '0;
  logic             burstBusy, burstDone, rdValid, rdEntValid;
  logic [KEY_W-1:0] rdData, rdMask;
  logic             srchEn = 1'b0;
  logic [KEY_W-1:0] srchKey = '0;
  logic             srchValid, srchHit;
  logic [IDX_W-1:0] srchIdx;

  prefixMatchTable #(.KEY_W(KEY_W), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rstN(rstN), .gmaskWe(gmaskWe), .gmaskIn(gmaskIn),
    .cmdStart(cmdStart), .cmdOp(cmdOp), .cmdAddr(cmdAddr), .cmdLen(cmdLen),
    .beatEn(beatEn), .beatData(beatData), .burstBusy(burstBusy),
    .burstDone(burstDone), .rdValid(rdValid), .rdData(rdData),
    .rdMask(rdMask), .rdEntValid(rdEntValid), .srchEn(srchEn),
    .srchKey(srchKey), .srchValid(srchValid), .srchHit(srchHit),
    .srchIdx(srchIdx)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit cmpOn  = 1'b0;

  task automatic chk(input string req, input logic [KEY_W-1:0] act,
                     input logic [KEY_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // ---------------- behavioural reference model ----------------
  logic [KEY_W-1:0] mData [DEPTH];
  logic [KEY_W-1:0] mMask [DEPTH];
  bit               mValid [DEPTH];
  logic [KEY_W-1:0] mG;
  bit               mBusy;
  int               mAddr, mRem, mOp, hitAt;
  logic [KEY_W-1:0] og;
  bit               eSV, eSH, eRV, eRE, eDone;
  int               eSI;
  logic [KEY_W-1:0] eRD, eRM;

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) begin
        mData[i] = '0; mMask[i] = '0; mValid[i] = 1'b0;
      end
      mG = '1; mBusy = 1'b0; mAddr = 0; mRem = 0; mOp = 0;
      eSV = 0; eSH = 0; eSI = 0; eRV = 0; eRE = 0; eRD = '0; eRM = '0; eDone = 0;
    end else begin
      og = mG;
      hitAt = -1;
      if (srchEn)
        for (int i = DEPTH - 1; i >= 0; i--)
          if (mValid[i] && (((srchKey ^ mData[i]) & mMask[i] & og) == '0)) hitAt = i;
      eSV = srchEn;
      eSH = (hitAt >= 0);
      eSI = (hitAt >= 0) ? hitAt : 0;
      eRV = 0; eRD = '0; eRM = '0; eRE = 0; eDone = 0;
      if (mBusy && beatEn) begin
        case (mOp)
          0: begin mData[mAddr] = (mData[mAddr] & ~og) | (beatData & og); mValid[mAddr] = 1'b1; end
          1: mMask[mAddr] = (mMask[mAddr] & ~og) | (beatData & og);
          2: begin eRV = 1; eRD = mData[mAddr]; eRM = mMask[mAddr]; eRE = mValid[mAddr]; end
          default: mValid[mAddr] = 1'b0;
        endcase
        mAddr = (mAddr + 1) % DEPTH;
        if (mRem == 0) begin mBusy = 1'b0; eDone = 1; end
        else mRem--;
      end else if (!mBusy && cmdStart) begin
        mBusy = 1'b1; mAddr = int'(cmdAddr); mRem = int'(cmdLen); mOp = int'(cmdOp);
      end
      if (gmaskWe) mG = gmaskIn;
    end
  end

  // compare on every falling edge, away from the active edge
  always @(negedge clk) begin
    if (cmpOn) begin
      chk("R2 srchValid", 32'(srchValid), 32'(eSV));
      chk("R3 R4 srchHit", 32'(srchHit), 32'(eSH));
      chk("R4 srchIdx", 32'(srchIdx), 32'(eSI));
      chk("R9 rdValid", 32'(rdValid), 32'(eRV));
      chk("R9 R5 rdData", rdData, eRD);
      chk("R9 R5 rdMask", rdMask, eRM);
      chk("R10 rdEntValid", 32'(rdEntValid), 32'(eRE));
      chk("R8 burstDone", 32'(burstDone), 32'(eDone));
      chk("R7 burstBusy", 32'(burstBusy), 32'(mBusy));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
      finishRun();
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic startCmd(input int op, input int addr, input int len);
    cmdStart = 1'b1; cmdOp = 2'(op); cmdAddr = IDX_W'(addr); cmdLen = IDX_W'(len);
    cyc();
    cmdStart = 1'b0;
  endtask

  task automatic beat(input logic [KEY_W-1:0] d);
    beatEn = 1'b1; beatData = d;
    cyc();
    beatEn = 1'b0;
  endtask

  task automatic search(input logic [KEY_W-1:0] k);
    srchEn = 1'b1; srchKey = k;
    cyc();
    srchEn = 1'b0;
  endtask

  task automatic setG(input logic [KEY_W-1:0] v);
    gmaskWe = 1'b1; gmaskIn = v;
    cyc();
    gmaskWe = 1'b0;
  endtask

  task automatic readOne(input int addr);
    startCmd(2, addr, 0);
    beat('0);
  endtask

  initial begin
    repeat (3) cyc();
    rstN = 1'b1;
    cmpOn = 1'b1;
    cyc();

    // R1: reset state, nothing valid even though care words are zero
    chk("R1 busy after reset", 32'(burstBusy), 0);
    search(32'h0);
    chk("R1 no hit after reset", 32'(srchHit), 0);
    chk("R2 miss index zero", 32'(srchIdx), 0);

    // R13 / R7: two 4-beat bursts load a sorted prefix table
    startCmd(0, 0, 3);
    beat(32'hC0A868E4); beat(32'hC0A86864); beat(32'hC0A86964); beat(32'hC0A86A64);
    chk("R8 done after value burst", 32'(burstDone), 1);
    startCmd(1, 0, 3);
    beat(32'hFFFFFF80); beat(32'hFFFFFF00); beat(32'hFFFFFE00); beat(32'hFFFFFC00);
    search(32'hC0A8687F);
    chk("R13 hit", 32'(srchHit), 1);
    chk("R13 index", 32'(srchIdx), 1);

    // R10 / R4: drop entries and the next lowest match takes over
    startCmd(3, 1, 0); beat('0);
    search(32'hC0A8687F);
    chk("R10 R4 index after invalidate", 32'(srchIdx), 2);
    startCmd(3, 2, 0); beat('0);
    search(32'hC0A8687F);
    chk("R4 index after second invalidate", 32'(srchIdx), 3);

    // R6: filter narrows every comparison to the top 16 bits
    search(32'hC0A80000);
    chk("R6 full filter miss", 32'(srchHit), 0);
    setG(32'hFFFF0000);
    search(32'hC0A80000);
    chk("R6 narrowed filter hit", 32'(srchHit), 1);
    chk("R6 narrowed filter index", 32'(srchIdx), 0);

    // R5: stores only touch filtered bits
    startCmd(0, 5, 0); beat(32'h1234ABCD);
    startCmd(1, 5, 0); beat(32'hFFFFFFFF);
    readOne(5);
    chk("R5 value merge", rdData, 32'h12340000);
    chk("R5 care merge", rdMask, 32'hFFFF0000);
    chk("R5 valid set", 32'(rdEntValid), 1);
    chk("R9 read strobe", 32'(rdValid), 1);
    setG(32'hFFFFFFFF);

    // R11: store and lookup in the same cycle
    startCmd(0, 4, 0);
    beatEn = 1'b1; beatData = 32'h0; srchEn = 1'b1; srchKey = 32'hDEADBEEF;
    cyc();
    beatEn = 1'b0; srchEn = 1'b0;
    chk("R11 same-cycle store unseen", 32'(srchHit), 0);
    search(32'hDEADBEEF);
    chk("R11 store seen next cycle", 32'(srchHit), 1);
    chk("R11 index next cycle", 32'(srchIdx), 4);

    // R12: command while busy is ignored
    startCmd(2, 0, 1);
    cmdStart = 1'b1; cmdOp = 2'b00; cmdAddr = 4'd9; cmdLen = 4'd0;
    cyc();
    cmdStart = 1'b0;
    beat('0);
    chk("R12 first read address kept", rdData, 32'hC0A868E4);
    chk("R9 first read care", rdMask, 32'hFFFFFF80);
    beat('0);
    chk("R12 second read address", rdData, 32'hC0A86864);
    chk("R10 invalid flag read", 32'(rdEntValid), 0);
    chk("R8 done pulse", 32'(burstDone), 1);
    chk("R8 busy low with done", 32'(burstBusy), 0);
    cyc();
    chk("R8 done single cycle", 32'(burstDone), 0);
    beat(32'hFFFFFFFF);
    readOne(9);
    chk("R12 entry untouched value", rdData, 32'h0);
    chk("R12 entry untouched valid", 32'(rdEntValid), 0);

    // R7: wrap past the last address, with a paused beat
    startCmd(0, 15, 1);
    beat(32'hAAAA0000);
    cyc();
    chk("R7 busy during pause", 32'(burstBusy), 1);
    beat(32'hBBBB0000);
    startCmd(2, 15, 1);
    beat('0);
    chk("R7 top entry", rdData, 32'hAAAA0000);
    beat('0);
    chk("R7 wrapped entry", rdData, 32'hBBBB0000);
    chk("R7 wrapped care kept", rdMask, 32'hFFFFFF80);

    // random phase, checked against the model each cycle
    for (int n = 0; n < 3000; n++) begin
      cmdStart = ($urandom % 6 == 0);
      cmdOp    = 2'($urandom);
      cmdAddr  = IDX_W'($urandom);
      cmdLen   = IDX_W'($urandom % 4);
      beatEn   = ($urandom % 2 == 0);
      case ($urandom % 3)
        0: beatData = 32'hC0A80000 | 32'($urandom % 8);
        1: beatData = 32'hFFFFFFFC;
        default: beatData = 32'hFFFF0000;
      endcase
      srchEn  = ($urandom % 2 == 0);
      srchKey = 32'hC0A80000 | 32'($urandom % 8);
      gmaskWe = ($urandom % 32 == 0);
      gmaskIn = ($urandom % 2 == 0) ? 32'hFFFFFFFF : 32'hFFFFFFFE;
      cyc();
    end
    cmdStart = 1'b0; beatEn = 1'b0; srchEn = 1'b0; gmaskWe = 1'b0;
    repeat (2) cyc();
    finishRun();
  end

endmodule